// File: doc/BRIEF.md
# Clock-Output Power-Down Sequencer

This block sits between a power-down request pin and the gating cells of a set of generated clock outputs. The request is active low and arrives with no timing relation to the block's clock. After synchronization, the request must be seen low on two consecutive reference-clock rising edges before the block acts on it. A single-sample glitch is dropped without touching any output.

Once the request is confirmed, the block watches the level of each generated clock. It raises that output's force-low control on the first edge at which the clock is seen to have gone from high to low. No clock is cut while it is high. Free-running outputs and the reference output are treated like every other output. When every force-low control is set, the block raises a stop flag that tells the oscillator and PLLs to shut down.

When the request is released, the stop flag drops first. All outputs stay forced low while a stabilization counter, advanced by a free-running tick, runs out. Then every force-low control is released in the same cycle. The generated-clock levels on `clk_phase` must be synchronous to `clk`, because they come from dividers in the same clock domain.

Top module: `pd_sequencer`

## Requirements
- R1: While reset is asserted and after its release, `state_o` is RUN (code 0), every `force_low` bit is 0 and `osc_stop` is 0.
- R2: The request is passed through a two-stage synchronizer. A synchronized low sample in RUN moves the block to CONFIRM (code 1). A second consecutive low sample moves it to DRAIN (code 2). The code of the state held after each clock edge appears on `state_o`.
- R3: If the synchronized request is high at the second sample, CONFIRM returns to RUN, and no `force_low` bit is set.
- R4: In DRAIN, bit i of `force_low` is set only on a clock edge where `clk_phase[i]` is sampled 0 after having been sampled 1 on the previous edge. Once set, the bit stays set.
- R5: After all `force_low` bits are set, the block enters OFF (code 3). `osc_stop` is 1 exactly while the state is OFF.
- R6: Releasing the request during DRAIN does not stop the sequence: the block still finishes draining and enters OFF.
- R7: In OFF, a synchronized high request moves the block to WAKE (code 4). In WAKE, `osc_stop` is 0 and every `force_low` bit stays 1.
- R8: The block leaves WAKE for RUN on the edge that samples the STAB_TICKS-th `tick` pulse counted in WAKE. All `force_low` bits clear on that same edge.
- R9: A synchronized low request during WAKE returns the block to OFF with all outputs still forced. The stabilization count restarts from zero on the next WAKE.
- R10: `force_low` bits are never cleared one at a time. Any clearing leaves all of them 0, with the state in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| tick | input | 1 | Free-running single-cycle pulse that times the stabilization interval |
| clk_phase | input | N_OUT | Current level of each generated clock output |
| force_low | output | N_OUT | Per-output control that holds the clock low |
| osc_stop | output | 1 | Tells the oscillator and PLLs to stop |
| state_o | output | 3 | Current state code |

## Verification
On every cycle, the bound checker enforces the following. Each force-low bit may rise only right after a falling edge of its clock. Force-low bits clear only together, and only into RUN. The stop flag appears only in a fully forced OFF state. DRAIN is entered only from CONFIRM. WAKE keeps every output held, and WAKE exits only on a tick. The directed scenarios cover what a single-cycle property cannot: the exact two-sample confirmation latency, the one-sample abort, release during drain, re-entry to power-down during wake, and the exact number of ticks spent in each WAKE.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_CONFIRM = 3'd1,
    ST_DRAIN   = 3'd2,
    ST_OFF     = 3'd3,
    ST_WAKE    = 3'd4
  } pd_state_t;
endpackage

// File: rtl/pdseq_sync.sv
// Multi-stage synchronizer; resets to the "request idle" level.
module pdseq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pdseq_gate.sv
// One output: sets its hold-low control on the first observed falling edge
// of its clock while armed; cleared only by the common release.
module pdseq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic arm,
  input  logic clear,
  output logic forced
);
  logic prev_q;
  logic forced_d;

  always_comb begin
    forced_d = forced;
    if (clear)                      forced_d = 1'b0;
    else if (arm && prev_q && !phase) forced_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      forced <= 1'b0;
    end else begin
      prev_q <= phase;
      forced <= forced_d;
    end
  end
endmodule

// File: rtl/pdseq_stab.sv
// Stabilization timer: counts tick pulses while enabled.
module pdseq_stab #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = en && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_low,
  input  logic      all_forced,
  input  logic      stab_done,
  output pd_state_t state,
  output logic      drain_arm,
  output logic      wake_en,
  output logic      release_all,
  output logic      osc_stop
);
  pd_state_t state_d;
  logic      stop_q;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RUN:     if (req_low) state_d = ST_CONFIRM;
      ST_CONFIRM: state_d = req_low ? ST_DRAIN : ST_RUN;
      ST_DRAIN:   if (all_forced) state_d = ST_OFF;
      ST_OFF:     if (!req_low) state_d = ST_WAKE;
      ST_WAKE: begin
        if (req_low)        state_d = ST_OFF;
        else if (stab_done) state_d = ST_RUN;
      end
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      stop_q <= 1'b0;
    end else begin
      state  <= state_d;
      stop_q <= (state_d == ST_OFF);
    end
  end

  assign drain_arm   = (state == ST_DRAIN);
  assign wake_en     = (state == ST_WAKE);
  assign release_all = (state == ST_WAKE) && !req_low && stab_done;
  assign osc_stop    = stop_q;
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pdseq_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STAB_TICKS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req_n,
  input  logic             tick,
  input  logic [N_OUT-1:0] clk_phase,
  output logic [N_OUT-1:0] force_low,
  output logic             osc_stop,
  output logic [2:0]       state_o
);
  logic      req_n_s;
  logic      req_low;
  logic      all_forced;
  logic      stab_done;
  logic      drain_arm;
  logic      wake_en;
  logic      release_all;
  pd_state_t st;

  pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_req_n), .q(req_n_s)
  );
  assign req_low = !req_n_s;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    pdseq_gate u_gate (
      .clk(clk), .rst_n(rst_n), .phase(clk_phase[g]),
      .arm(drain_arm), .clear(release_all), .forced(force_low[g])
    );
  end
  assign all_forced = &force_low;

  pdseq_stab #(.TICKS(STAB_TICKS)) u_stab (
    .clk(clk), .rst_n(rst_n), .en(wake_en), .tick(tick), .done(stab_done)
  );

  pdseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_low(req_low), .all_forced(all_forced),
    .stab_done(stab_done), .state(st), .drain_arm(drain_arm),
    .wake_en(wake_en), .release_all(release_all), .osc_stop(osc_stop)
  );

  assign state_o = st;
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [N_OUT-1:0] clk_phase,
  input logic [N_OUT-1:0] force_low,
  input logic             osc_stop,
  input logic [2:0]       state_o
);
  // R10
  force_fall_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(force_low) & ~force_low)) |-> (force_low == '0 && state_o == 3'd0));

  // R5
  osc_stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> (state_o == 3'd3 && (&force_low)));

  // R2
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |-> ($past(state_o) == 3'd1));

  // R7
  wake_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |-> ((&force_low) && !osc_stop));

  // R8
  wake_exit_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd4 && state_o == 3'd0) |-> $past(tick));

  for (genvar g = 0; g < N_OUT; g++) begin : g_bit
    // R4
    rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(force_low[g]) |-> (!$past(clk_phase[g]) && $past(clk_phase[g], 2)));
  end
endmodule

bind pd_sequencer pd_sequencer_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clk_phase(clk_phase),
  .force_low(force_low), .osc_stop(osc_stop), .state_o(state_o)
);

// File: tb/pd_sequencer_test.sv
module pd_sequencer_test;
  localparam int N    = 4;
  localparam int STAB = 8;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pd_req_n = 1'b1;
  logic         tick = 1'b0;
  logic [N-1:0] clk_phase = '0;
  logic [N-1:0] force_low;
  logic         osc_stop;
  logic [2:0]   state_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pd_sequencer #(.N_OUT(N), .SYNC_STAGES(2), .STAB_TICKS(STAB)) uut (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .tick(tick),
    .clk_phase(clk_phase), .force_low(force_low), .osc_stop(osc_stop),
    .state_o(state_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Stimulus for phases and tick, plus per-edge monitors (R4, R8, R10).
  int          div_cnt [N];
  logic [N-1:0] ph_prev = '0;
  logic [N-1:0] f_prev  = '0;
  logic [2:0]   st_prev = 3'd0;
  int          tick_cnt = 0;
  int          wake_ticks = 0;

  initial for (int i = 0; i < N; i++) div_cnt[i] = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (force_low[i] && !f_prev[i])  // R4
          chk(!clk_phase[i] && ph_prev[i], "R4", "force rise not on falling edge",
              {30'd0, ph_prev[i], clk_phase[i]}, 2);
      end
      if ((f_prev & ~force_low) != '0)  // R10
        chk(force_low == '0 && state_o == 3'd0, "R10", "partial release",
            int'(force_low), 0);
      if (st_prev != 3'd4 && state_o == 3'd4) wake_ticks = 0;
      else if (st_prev == 3'd4 && tick) wake_ticks++;
      if (st_prev == 3'd4 && state_o == 3'd0)  // R8
        chk(wake_ticks == STAB && force_low == '0, "R8", "ticks in WAKE",
            wake_ticks, STAB);
    end
    ph_prev = clk_phase;
    f_prev  = force_low;
    st_prev = state_o;
    for (int i = 0; i < N; i++) begin
      div_cnt[i]++;
      if (div_cnt[i] >= 2 * i + 2) begin
        div_cnt[i] = 0;
        clk_phase[i] = ~clk_phase[i];
      end
    end
    tick_cnt++;
    tick = (tick_cnt % 3 == 0);
  end

  task automatic wait_state(input logic [2:0] s, input int limit, input string req);
    int n = 0;
    while (state_o != s && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(state_o == s, req, "state reached", int'(state_o), int'(s));
  endtask

  task automatic t_reset;
    chk(state_o == 3'd0, "R1", "state after reset", int'(state_o), 0);
    chk(force_low == '0, "R1", "force after reset", int'(force_low), 0);
    chk(osc_stop == 1'b0, "R1", "osc_stop after reset", int'(osc_stop), 0);
  endtask

  task automatic t_abort;
    bit bad = 0;
    bit saw_c = 0;
    @(negedge clk) pd_req_n = 1'b0;
    @(negedge clk) pd_req_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (state_o == 3'd1) saw_c = 1;
      if (state_o == 3'd2 || force_low != '0) bad = 1;
    end
    chk(saw_c, "R3", "glitch reached CONFIRM", int'(saw_c), 1);
    chk(!bad, "R3", "glitch reached DRAIN or forced", int'(bad), 0);
    chk(state_o == 3'd0, "R3", "back in RUN", int'(state_o), 0);
  endtask

  task automatic t_full;
    @(negedge clk) pd_req_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(state_o == 3'd1, "R2", "CONFIRM after sync", int'(state_o), 1);
    @(negedge clk);
    chk(state_o == 3'd2, "R2", "DRAIN after second sample", int'(state_o), 2);
    chk(osc_stop == 1'b0, "R5", "osc_stop in DRAIN", int'(osc_stop), 0);
    wait_state(3'd3, 100, "R5");
    chk(force_low == ALL, "R5", "all forced in OFF", int'(force_low), int'(ALL));
    chk(osc_stop == 1'b1, "R5", "osc_stop in OFF", int'(osc_stop), 1);
    @(negedge clk) pd_req_n = 1'b1;
    wait_state(3'd4, 10, "R7");
    chk(osc_stop == 1'b0, "R7", "osc_stop in WAKE", int'(osc_stop), 0);
    chk(force_low == ALL, "R7", "held in WAKE", int'(force_low), int'(ALL));
    wait_state(3'd0, 100, "R8");
    chk(force_low == '0, "R8", "released in RUN", int'(force_low), 0);
  endtask

  task automatic t_release_in_drain;
    @(negedge clk) pd_req_n = 1'b0;
    wait_state(3'd2, 10, "R6");
    pd_req_n = 1'b1;
    wait_state(3'd3, 100, "R6");
    chk(force_low == ALL, "R6", "drain completed", int'(force_low), int'(ALL));
    wait_state(3'd0, 200, "R6");
  endtask

  task automatic t_rewake;
    @(negedge clk) pd_req_n = 1'b0;
    wait_state(3'd3, 100, "R9");
    @(negedge clk) pd_req_n = 1'b1;
    wait_state(3'd4, 10, "R9");
    repeat (6) @(negedge clk);
    pd_req_n = 1'b0;
    wait_state(3'd3, 10, "R9");
    chk(force_low == ALL, "R9", "still forced after re-entry", int'(force_low), int'(ALL));
    chk(osc_stop == 1'b1, "R9", "osc_stop after re-entry", int'(osc_stop), 1);
    @(negedge clk) pd_req_n = 1'b1;
    wait_state(3'd0, 200, "R9");
    chk(force_low == '0, "R9", "released after full count", int'(force_low), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_abort();
    t_full();
    repeat (5) @(negedge clk);
    t_release_in_drain();
    repeat (5) @(negedge clk);
    t_rewake();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule